// File: doc/BRIEF.md
# Bit-serial PHY tuning writer

This block writes multi-bit tuning values into a PHY's internal tuning space through one shared 32-bit control word. The PHY accepts a single bit per strobe pulse. The block therefore breaks each field into single-bit writes. Bit j of the value goes to bit-address `start + j`, lowest bit first. For each bit, the block first loads the address field and the data bit while the strobe is low. It then raises the selected port's strobe and lowers it again. Each of these three phases is held for a fixed number of clock cycles.

A write request carries four items: a start bit-address, a data value, a bit count and a port number. The block takes one request at a time and reports `busy` while it works. When a write ends, the block raises `done` for a single cycle.

The block also holds a built-in power-up tuning sequence that runs two writes in a row:
- an amplitude and rate field of 5 bits, value 0x14, at bit-address 0x20;
- a disconnect threshold field of 2 bits at bit-address 0x2A, value 3 or 2, chosen by an input.

Top module: `phy_tune_writer`

## Requirements
- R1: After reset, `ctrl_word` equals the parameter `INIT_WORD` (default 32'h5A00_000A), and `busy` and `done` are 0.
- R2: A request (`req_valid` or `boot_go`) is taken only in a cycle where `busy` is 0. A taken request with a non-zero length makes `busy` 1 from the next cycle. Requests presented while `busy` is 1 are ignored and produce no strobe.
- R3: While bit j of a write is being sent, `ctrl_word[15:8]` holds (start address + j) mod 256. `ctrl_word[7]` holds bit j of the data, lowest bit first. Bit positions at or beyond `DATA_W` are sent as 0.
- R4: Each bit takes 3×`PHASE_CYC` cycles. The first `PHASE_CYC` cycles are setup with the strobe low. The next `PHASE_CYC` cycles have the strobe high, and the last `PHASE_CYC` cycles have it low. The strobe of port n is `ctrl_word[2n]`. Address and data stay stable while the strobe is high, and at most one strobe bit is high at a time.
- R5: `ctrl_word` bits outside [15:7], and outside the active port's strobe bit, keep their values.
- R6: `done` is 1 for exactly the cycle after the last strobe-low phase of a write. `busy` is 0 in that cycle.
- R7: A request with length 0 gives `done` in the next cycle. It does not raise `busy` and leaves `ctrl_word` unchanged.
- R8: `boot_go` runs two writes on port `BOOT_PORT`. The first writes 0x14 over 5 bits at 0x20. The second writes 2 bits at 0x2A: value 3 when `boot_thresh_hi` is 1, otherwise 2. Exactly one cycle separates the two writes. `busy` stays 1 throughout, and `done` pulses once, after the second write only.
- R9: When `boot_go` and `req_valid` arrive in the same idle cycle, the boot sequence runs and the external request is dropped.
- R10: A request presented in the `done` cycle is taken. Its first bit loads on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | External write request |
| req_addr | input | 8 | Start bit-address |
| req_data | input | DATA_W | Value, sent lowest bit first |
| req_len | input | LEN_W | Number of bits to write |
| req_port | input | PORT_W | Target port (strobe bit 2×port) |
| boot_go | input | 1 | Start the power-up tuning sequence |
| boot_thresh_hi | input | 1 | Threshold choice for the boot sequence: 1 gives 3, 0 gives 2 |
| ctrl_word | output | 32 | Shared control word |
| busy | output | 1 | A write or the boot sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: one write's `done` cycle and the acceptance of the next request. To provoke this, the bench watches for `done` and presents a new request in that very cycle. The bench model expects the new first address and data bit to load on the very next edge, with no idle cycle and no extra `done`. The bench also provokes a second same-cycle case: `boot_go` and `req_valid` together. Here the port's strobe count and the tuning bits it latched must show that the external request left no trace.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;

  localparam int WORD_W   = 32;
  localparam int ADDR_LSB = 8;
  localparam int ADDR_W   = 8;
  localparam int DATA_POS = 7;

  localparam logic [7:0] BOOT_AMP_ADDR = 8'h20;
  localparam logic [7:0] BOOT_AMP_VAL  = 8'h14;
  localparam int         BOOT_AMP_LEN  = 5;
  localparam logic [7:0] BOOT_THR_ADDR = 8'h2A;
  localparam logic [7:0] BOOT_THR_HI   = 8'h03;
  localparam logic [7:0] BOOT_THR_LO   = 8'h02;
  localparam int         BOOT_THR_LEN  = 2;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_LOW
  } phase_e;

  // bit-address of the bit at offset off, wrapping in the 8-bit space
  function automatic logic [ADDR_W-1:0] bit_addr(input logic [ADDR_W-1:0] start,
                                                 input logic [ADDR_W-1:0] off);
    return start + off;
  endfunction

  // single-bit mask for the strobe of a port: bit 2*port
  function automatic logic [WORD_W-1:0] strobe_bit(input int unsigned port);
    return WORD_W'(1) << (2 * port);
  endfunction

endpackage

// File: rtl/tune_phase_timer.sv
module tune_phase_timer #(
  parameter int PHASE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic phase_end
);
  localparam int CW = $clog2(PHASE_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign phase_end = active && (cnt_q == CW'(PHASE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!active || phase_end) cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end

  // R4: a phase never runs past its programmed length
  a_r4_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PHASE_CYC - 1));

endmodule

// File: rtl/tune_bit_engine.sv
module tune_bit_engine
  import phy_tune_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4,
  parameter int PORT_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   s_addr,
  input  logic [DATA_W-1:0]   s_data,
  input  logic [LEN_W-1:0]    s_len,
  input  logic [PORT_W-1:0]   s_port,
  input  logic                phase_end,
  output phase_e              phase,
  output logic                ev_load,
  output logic                ev_rise,
  output logic                ev_fall,
  output logic                ev_finish,
  output logic                ev_empty,
  output logic [ADDR_W-1:0]   load_addr,
  output logic                load_bit,
  output logic [PORT_W-1:0]   act_port
);

  phase_e              phase_q;
  logic [LEN_W-1:0]    j_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q;
  logic [LEN_W-1:0]    len_q;
  logic [PORT_W-1:0]   port_q;

  logic                accept_go;
  logic                last_bit;
  logic [LEN_W-1:0]    j_next;

  // value of bit idx; positions past the data width shift out as 0
  function automatic logic data_at(input logic [DATA_W-1:0] d, input logic [LEN_W-1:0] idx);
    logic [DATA_W-1:0] sh;
    sh = d >> idx;
    return sh[0];
  endfunction

  assign phase     = phase_q;
  assign accept_go = start && (phase_q == PH_IDLE);
  assign last_bit  = (j_q == len_q - LEN_W'(1));
  assign j_next    = j_q + LEN_W'(1);

  assign ev_empty  = accept_go && (s_len == '0);
  assign ev_rise   = (phase_q == PH_SETUP) && phase_end;
  assign ev_fall   = (phase_q == PH_HIGH) && phase_end;
  assign ev_finish = (phase_q == PH_LOW) && phase_end && last_bit;
  assign ev_load   = (accept_go && (s_len != '0)) ||
                     ((phase_q == PH_LOW) && phase_end && !last_bit);

  assign load_addr = accept_go ? s_addr : bit_addr(addr_q, ADDR_W'(j_next));
  assign load_bit  = accept_go ? data_at(s_data, '0) : data_at(data_q, j_next);
  assign act_port  = accept_go ? s_port : port_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      j_q     <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      len_q   <= '0;
      port_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (accept_go && (s_len != '0)) begin
          phase_q <= PH_SETUP;
          j_q     <= '0;
          addr_q  <= s_addr;
          data_q  <= s_data;
          len_q   <= s_len;
          port_q  <= s_port;
        end
        PH_SETUP: if (phase_end) phase_q <= PH_HIGH;
        PH_HIGH:  if (phase_end) phase_q <= PH_LOW;
        PH_LOW:   if (phase_end) begin
          if (last_bit) phase_q <= PH_IDLE;
          else begin
            j_q     <= j_next;
            phase_q <= PH_SETUP;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R3: the bit index stays inside the requested length
  a_r3_index_in_len: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> (j_q < len_q));

  // R4: a strobe rise is always followed by a fall before the next load
  a_r4_rise_then_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rise |=> (phase_q == PH_HIGH));

endmodule

// File: rtl/tune_ctrl_word.sv
module tune_ctrl_word
  import phy_tune_pkg::*;
#(
  parameter logic [31:0] INIT_WORD = 32'h5A00_000A,
  parameter int          PORT_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_load,
  input  logic                ev_rise,
  input  logic                ev_fall,
  input  logic [ADDR_W-1:0]   load_addr,
  input  logic                load_bit,
  input  logic [PORT_W-1:0]   port,
  output logic [WORD_W-1:0]   word
);

  function automatic logic [WORD_W-1:0] all_strobes();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < (1 << PORT_W); i++) m = m | strobe_bit(i);
    return m;
  endfunction

  localparam logic [WORD_W-1:0] STB_ALL   = all_strobes();
  localparam logic [WORD_W-1:0] FIELD_MSK = WORD_W'(32'h0000_FF80);
  localparam logic [WORD_W-1:0] FREE_MSK  = ~(STB_ALL | FIELD_MSK);

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] smask;

  assign smask = strobe_bit(32'(port));
  assign word  = word_q;

  always_comb begin
    word_d = word_q;
    if (ev_load) begin
      word_d[ADDR_LSB +: ADDR_W] = load_addr;
      word_d[DATA_POS]           = load_bit;
      word_d                     = word_d & ~smask;
    end
    if (ev_rise) word_d = word_d | smask;
    if (ev_fall) word_d = word_d & ~smask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= INIT_WORD;
    else        word_q <= word_d;
  end

  // R5: bits outside the fields and strobes never move
  a_r5_free_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(word_q & FREE_MSK));

  // R4: never more than one port strobe high
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_q & STB_ALL));

endmodule

// File: rtl/tune_req_arbiter.sv
module tune_req_arbiter
  import phy_tune_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LEN_W     = 4,
  parameter int PORT_W    = 2,
  parameter int BOOT_PORT = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_data,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [PORT_W-1:0]   req_port,
  input  logic                boot_go,
  input  logic                boot_thresh_hi,
  input  logic                eng_idle,
  input  logic                eng_finish,
  output logic                start,
  output logic [ADDR_W-1:0]   s_addr,
  output logic [DATA_W-1:0]   s_data,
  output logic [LEN_W-1:0]    s_len,
  output logic [PORT_W-1:0]   s_port,
  output logic                boot_busy,
  output logic                hide_done
);

  typedef enum logic [1:0] {B_OFF, B_AMP, B_GAP, B_THR} boot_e;

  boot_e bst_q;
  logic  thr_hi_q;
  logic  free;

  assign free      = eng_idle && (bst_q == B_OFF);
  assign boot_busy = (bst_q != B_OFF);
  assign hide_done = (bst_q == B_AMP);

  always_comb begin
    start  = 1'b0;
    s_addr = req_addr;
    s_data = req_data;
    s_len  = req_len;
    s_port = req_port;
    if (free && boot_go) begin
      start  = 1'b1;
      s_addr = BOOT_AMP_ADDR;
      s_data = DATA_W'(BOOT_AMP_VAL);
      s_len  = LEN_W'(BOOT_AMP_LEN);
      s_port = PORT_W'(BOOT_PORT);
    end else if (bst_q == B_GAP) begin
      start  = 1'b1;
      s_addr = BOOT_THR_ADDR;
      s_data = thr_hi_q ? DATA_W'(BOOT_THR_HI) : DATA_W'(BOOT_THR_LO);
      s_len  = LEN_W'(BOOT_THR_LEN);
      s_port = PORT_W'(BOOT_PORT);
    end else if (free && req_valid) begin
      start  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bst_q    <= B_OFF;
      thr_hi_q <= 1'b0;
    end else begin
      case (bst_q)
        B_OFF: if (free && boot_go) begin
          bst_q    <= B_AMP;
          thr_hi_q <= boot_thresh_hi;
        end
        B_AMP: if (eng_finish) bst_q <= B_GAP;
        B_GAP: bst_q <= B_THR;
        B_THR: if (eng_finish) bst_q <= B_OFF;
        default: bst_q <= B_OFF;
      endcase
    end
  end

  // R8: the gap cycle always finds the engine idle, so the second write starts at once
  a_r8_gap_engine_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_q == B_GAP) |-> eng_idle);

endmodule

// File: rtl/phy_tune_writer.sv
module phy_tune_writer
  import phy_tune_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          LEN_W     = 4,
  parameter int          PORT_W    = 2,
  parameter int          PHASE_CYC = 2,
  parameter int          BOOT_PORT = 1,
  parameter logic [31:0] INIT_WORD = 32'h5A00_000A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [7:0]         req_addr,
  input  logic [DATA_W-1:0]  req_data,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [PORT_W-1:0]  req_port,
  input  logic               boot_go,
  input  logic               boot_thresh_hi,
  output logic [31:0]        ctrl_word,
  output logic               busy,
  output logic               done
);

  phase_e              phase;
  logic                phase_end;
  logic                ev_load, ev_rise, ev_fall, ev_finish, ev_empty;
  logic [ADDR_W-1:0]   load_addr;
  logic                load_bit;
  logic [PORT_W-1:0]   act_port;
  logic                start;
  logic [ADDR_W-1:0]   s_addr;
  logic [DATA_W-1:0]   s_data;
  logic [LEN_W-1:0]    s_len;
  logic [PORT_W-1:0]   s_port;
  logic                boot_busy;
  logic                hide_done;
  logic                eng_idle;
  logic                done_q;

  assign eng_idle = (phase == PH_IDLE);
  assign busy     = !eng_idle || boot_busy;
  assign done     = done_q;

  tune_req_arbiter #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .PORT_W(PORT_W), .BOOT_PORT(BOOT_PORT)
  ) u_arb (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .req_len(req_len), .req_port(req_port),
    .boot_go(boot_go), .boot_thresh_hi(boot_thresh_hi),
    .eng_idle(eng_idle), .eng_finish(ev_finish),
    .start(start), .s_addr(s_addr), .s_data(s_data), .s_len(s_len),
    .s_port(s_port), .boot_busy(boot_busy), .hide_done(hide_done)
  );

  tune_bit_engine #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .PORT_W(PORT_W)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start),
    .s_addr(s_addr), .s_data(s_data), .s_len(s_len), .s_port(s_port),
    .phase_end(phase_end), .phase(phase),
    .ev_load(ev_load), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_finish(ev_finish), .ev_empty(ev_empty),
    .load_addr(load_addr), .load_bit(load_bit), .act_port(act_port)
  );

  tune_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .active(!eng_idle), .phase_end(phase_end)
  );

  tune_ctrl_word #(.INIT_WORD(INIT_WORD), .PORT_W(PORT_W)) u_word (
    .clk(clk), .rst_n(rst_n),
    .ev_load(ev_load), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .load_addr(load_addr), .load_bit(load_bit), .port(act_port),
    .word(ctrl_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= (ev_finish && !hide_done) || ev_empty;
  end

  // R6: completion is only reported once the block is free again
  a_r6_done_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2: a started non-empty write shows busy on the next cycle
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load && eng_idle) |=> busy);

  // R4: address and data hold while a strobe is high
  a_r4_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HIGH) |-> $stable(ctrl_word[15:7]));

  // R7: an empty request reports completion without going busy
  a_r7_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_empty |=> (done && !busy));

endmodule

// File: tb/phy_tune_writer_test.sv
module phy_tune_writer_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          PH   = 2;
  localparam int          DW   = 8;
  localparam int          LW   = 4;
  localparam int          PW   = 2;
  localparam int          BP   = 1;
  localparam logic [31:0] INIT = 32'h5A00_000A;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [LW-1:0] req_len = '0;
  logic [PW-1:0] req_port = '0;
  logic          boot_go = 1'b0;
  logic          boot_thresh_hi = 1'b0;
  logic [31:0]   ctrl_word;
  logic          busy;
  logic          done;

  phy_tune_writer #(
    .DATA_W(DW), .LEN_W(LW), .PORT_W(PW), .PHASE_CYC(PH),
    .BOOT_PORT(BP), .INIT_WORD(INIT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_len(req_len), .req_port(req_port),
    .boot_go(boot_go), .boot_thresh_hi(boot_thresh_hi),
    .ctrl_word(ctrl_word), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    done_seen = 0;
  string tag = "R1";

  task automatic check(input bit ok, input string t, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // ---------------- reference model: queue of expected cycles ----------------
  logic [31:0] exp_word = INIT;
  bit          exp_busy = 0;
  bit          exp_done = 0;
  logic [31:0] qw [$];
  bit          qb [$];
  bit          qd [$];

  task automatic push(input logic [31:0] w, input bit b, input bit d);
    qw.push_back(w); qb.push_back(b); qd.push_back(d);
  endtask

  task automatic plan_bits(inout logic [31:0] w, input int addr, input int data,
                           input int len, input int port);
    for (int j = 0; j < len; j++) begin
      int bitv;
      bitv = (j < DW) ? ((data >> j) & 1) : 0;
      w[15:8] = 8'((addr + j) % 256);
      w[7]    = bitv[0];
      w[2*port] = 1'b0;
      for (int k = 0; k < PH; k++) push(w, 1, 0);
      w[2*port] = 1'b1;
      for (int k = 0; k < PH; k++) push(w, 1, 0);
      w[2*port] = 1'b0;
      for (int k = 0; k < PH; k++) push(w, 1, 0);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_word = INIT; exp_busy = 0; exp_done = 0;
      qw.delete(); qb.delete(); qd.delete();
    end else begin
      if (!exp_busy && (boot_go || req_valid)) begin
        logic [31:0] w;
        w = exp_word;
        if (boot_go) begin
          plan_bits(w, 'h20, 'h14, 5, BP);
          push(w, 1, 0);
          plan_bits(w, 'h2A, boot_thresh_hi ? 3 : 2, 2, BP);
        end else begin
          plan_bits(w, int'(req_addr), int'(req_data), int'(req_len), int'(req_port));
        end
        push(w, 0, 1);
      end
      if (qw.size() > 0) begin
        exp_word = qw.pop_front(); exp_busy = qb.pop_front(); exp_done = qd.pop_front();
      end else begin
        exp_busy = 0; exp_done = 0;
      end
    end
  end

  // ---------------- PHY-side model: latch on strobe rise ----------------
  bit          phy_mem [4][256];
  int          rises [4];
  logic [31:0] prev_word = INIT;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < 4; p++)
        if (ctrl_word[2*p] && !prev_word[2*p]) begin
          phy_mem[p][ctrl_word[15:8]] = ctrl_word[7];
          rises[p]++;
        end
      if (done) done_seen++;
      check(ctrl_word == exp_word && busy == exp_busy && done == exp_done, tag,
            "cycle word/busy/done", longint'({ctrl_word, busy, done}),
            longint'({exp_word, exp_busy, exp_done}));
    end
    prev_word = ctrl_word;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic send_req(input logic [7:0] a, input logic [DW-1:0] d,
                          input logic [LW-1:0] l, input logic [PW-1:0] p);
    @(negedge clk);
    req_addr = a; req_data = d; req_len = l; req_port = p; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ctrl_word == INIT, "R1", "reset word", longint'(ctrl_word), longint'(INIT));
    check(busy == 1'b0, "R1", "reset busy", longint'(busy), 0);
    check(done == 1'b0, "R1", "reset done", longint'(done), 0);

    // R3 R4: plain byte write on port 1, with an R2 request while busy
    tag = "R3 R4 R6 R2";
    send_req(8'h10, 8'hA5, 4'd8, 2'd1);
    repeat (5) @(negedge clk);
    send_req(8'h80, 8'hFF, 4'd4, 2'd2);
    wait_done();
    for (int j = 0; j < 8; j++)
      check(phy_mem[1][8'h10 + j] == ((8'hA5 >> j) & 1), "R3", "latched bit",
            longint'(phy_mem[1][8'h10 + j]), longint'((8'hA5 >> j) & 1));
    check(rises[1] == 8, "R4", "strobe pulses port 1", rises[1], 8);
    check(rises[2] == 0, "R2", "ignored request pulses", rises[2], 0);

    // R3: address wrap on port 3
    tag = "R3 R4";
    @(negedge clk);
    send_req(8'hFE, 8'h05, 4'd3, 2'd3);
    wait_done();
    check(phy_mem[3][8'hFE] == 1 && phy_mem[3][8'hFF] == 0 && phy_mem[3][8'h00] == 1,
          "R3", "wrap bits", longint'({phy_mem[3][8'hFE], phy_mem[3][8'hFF], phy_mem[3][8'h00]}), 5);

    // R3: length beyond the data width sends zeros
    @(negedge clk);
    send_req(8'h40, 8'hFF, 4'd10, 2'd0);
    wait_done();
    check(rises[0] == 10, "R3", "pulses for long write", rises[0], 10);
    check(phy_mem[0][8'h47] == 1 && phy_mem[0][8'h48] == 0 && phy_mem[0][8'h49] == 0,
          "R3", "bits past width", longint'({phy_mem[0][8'h47], phy_mem[0][8'h48], phy_mem[0][8'h49]}), 4);

    // R7: empty request
    tag = "R7";
    begin
      logic [31:0] w0;
      int r0;
      @(negedge clk);
      w0 = ctrl_word; r0 = rises[0] + rises[1] + rises[2] + rises[3];
      send_req(8'h33, 8'hFF, 4'd0, 2'd2);
      check(done == 1'b1 && busy == 1'b0, "R7", "empty done/busy", longint'({done, busy}), 2);
      check(ctrl_word == w0, "R7", "empty word", longint'(ctrl_word), longint'(w0));
      @(negedge clk);
      check(rises[0] + rises[1] + rises[2] + rises[3] == r0, "R7", "empty pulses",
            rises[0] + rises[1] + rises[2] + rises[3], r0);
    end

    // R10: request presented in the done cycle
    tag = "R10 R6";
    begin
      int r2;
      r2 = rises[2];
      send_req(8'h60, 8'h03, 4'd2, 2'd2);
      wait_done();
      req_addr = 8'h62; req_data = 8'h01; req_len = 4'd1; req_port = 2'd2; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(busy == 1'b1, "R10", "busy after done-cycle request", longint'(busy), 1);
      wait_done();
      check(rises[2] == r2 + 3, "R10", "pulses back-to-back", rises[2], r2 + 3);
      check(phy_mem[2][8'h62] == 1, "R10", "second write bit", longint'(phy_mem[2][8'h62]), 1);
    end

    // R8: boot sequence, high threshold then low
    tag = "R8";
    for (int pass = 0; pass < 2; pass++) begin
      int d0;
      @(negedge clk);
      d0 = done_seen;
      boot_thresh_hi = (pass == 0);
      boot_go = 1'b1;
      @(negedge clk);
      boot_go = 1'b0;
      wait_done();
      @(negedge clk);
      check(done_seen == d0 + 1, "R8", "single boot done", done_seen, d0 + 1);
      for (int j = 0; j < 5; j++)
        check(phy_mem[BP][8'h20 + j] == ((8'h14 >> j) & 1), "R8", "amp bit",
              longint'(phy_mem[BP][8'h20 + j]), longint'((8'h14 >> j) & 1));
      check(phy_mem[BP][8'h2A] == (pass == 0) && phy_mem[BP][8'h2B] == 1, "R8",
            "threshold bits", longint'({phy_mem[BP][8'h2B], phy_mem[BP][8'h2A]}),
            (pass == 0) ? 3 : 2);
    end

    // R9: boot and external request in the same cycle
    tag = "R9";
    begin
      int r3;
      r3 = rises[3];
      req_addr = 8'hC0; req_data = 8'hFF; req_len = 4'd1; req_port = 2'd3;
      boot_thresh_hi = 1'b1;
      req_valid = 1'b1; boot_go = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; boot_go = 1'b0;
      wait_done();
      @(negedge clk);
      check(rises[3] == r3, "R9", "dropped request pulses", rises[3], r3);
      check(phy_mem[3][8'hC0] == 0, "R9", "dropped request bit", longint'(phy_mem[3][8'hC0]), 0);
    end

    // R5: untouched bits at the end of the run
    check(((ctrl_word ^ INIT) & ~32'h0000_FFD5) == 0, "R5", "free bits",
          longint'(ctrl_word & ~32'h0000_FFD5), longint'(INIT & ~32'h0000_FFD5));

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule